// File: doc/BRIEF.md
# Audio Mixer Control Word Decoder

This block sits behind the serial control port of a small audio subsystem. Each time the port commits a complete 8-bit control word, the block raises nothing itself: it receives the word with a one-cycle strobe. It stores the word into one of five control fields. A short prefix code in the upper bits of the word selects the field. The prefix is either three or four bits long, so a volume word keeps five payload bits and a mode or effect word keeps four.

From the stored fields, the block derives the settings the analog side needs. It gives one bridged speaker output and two headphone outputs each a shutdown, mute or live state. For each output it also gives the set of sources summed into it. It gives each of the three sources (mono, left, right) a headphone gain and a speaker gain in signed half-dB units, and it passes on the stereo widening effect settings and the headphone output-capacitor flag. The block does not mix or amplify anything. It only decodes, and every output is registered.

Top module: `mix_ctl_decoder`

## Requirements
- R1: After reset, the output mode is 0, the no-capacitor flag is 0, all volume codes are 0 and the effect field is 0. All outputs therefore show shutdown, empty routes, headphone gains of -108 and speaker gains of -96 half-dB, and the effect is off.
- R2: A strobed word whose bits 7:4 are 0000 stores bit 3 as the no-capacitor flag (output `hp_no_cap`) and bits 2:0 as the output mode.
- R3: A strobed word whose bits 7:4 are 0100 stores the effect field. Bit 0 drives `fx_en`, bit 1 drives `fx_cfg`, and bits 3:2 drive `fx_level` (00 low, 01 medium, 10 high, 11 maximum).
- R4: A strobed word whose bits 7:5 are 100, 110 or 111 stores bits 4:0 as the mono, left or right volume code respectively. The other two codes do not change.
- R5: The headphone gain in half-dB for volume codes 0 to 9 is -108, -93, -81, -69, -60, -54, -48, -42, -36, -30. For code c from 10 to 31 it is -27 + 3*(c-10), so code 31 gives +36.
- R6: Each source's speaker gain equals its headphone gain plus 12 half-dB.
- R7: Output states use the encoding 0 shutdown, 1 mute, 2 live. The states are {speaker, left headphone, right headphone}: modes 0 {0,0,0}, 1 {2,1,1}, 2 {0,2,2}, 3 {2,1,1}, 4 {0,2,2}, 5 {2,1,1}, 6 {0,2,2}, 7 {2,2,2}.
- R8: `spk_route` uses bit 0 for left, bit 1 for right and bit 2 for mono. Its values by mode 0..7 are 000, 100, 000, 011, 000, 111, 000, 100. Each headphone route uses bit 0 for its own stereo channel and bit 1 for mono. By mode the headphone routes are 00, 00, 10, 00, 01, 00, 11, 11, and both headphones always carry the same value.
- R9: A strobed word whose bits 7:4 are 0001, 0010, 0011, 0101, 0110 or 0111, or whose bits 7:5 are 101, changes no stored field and no output.
- R10: A strobed word is visible on every output at the clock edge that samples the strobe. Without a strobe the outputs hold, whatever `wr_byte` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle strobe for a committed control word |
| wr_byte | input | 8 | Committed control word |
| spk_state | output | 2 | Speaker state: 0 shutdown, 1 mute, 2 live |
| hpl_state | output | 2 | Left headphone state |
| hpr_state | output | 2 | Right headphone state |
| spk_route | output | 3 | Speaker sources {mono, right, left} |
| hpl_route | output | 2 | Left headphone sources {mono, left} |
| hpr_route | output | 2 | Right headphone sources {mono, right} |
| gain_hp_mono | output | 8 | Mono headphone gain, signed half-dB |
| gain_hp_left | output | 8 | Left headphone gain, signed half-dB |
| gain_hp_right | output | 8 | Right headphone gain, signed half-dB |
| gain_spk_mono | output | 8 | Mono speaker gain, signed half-dB |
| gain_spk_left | output | 8 | Left speaker gain, signed half-dB |
| gain_spk_right | output | 8 | Right speaker gain, signed half-dB |
| fx_en | output | 1 | Widening effect enable |
| fx_cfg | output | 1 | Widening effect configuration select |
| fx_level | output | 2 | Widening effect strength |
| hp_no_cap | output | 1 | Headphones driven without output capacitors |

## Verification
A register write and the decode of that write fall on the same clock edge, because the outputs are computed from the next-state value of the fields. The bench provokes this by issuing strobes on consecutive cycles that alternate between mode, volume and effect words. After each edge it judges that every output reflects all words written so far, with no stale cycle between them. It also places rejected-prefix words and unstrobed word changes between valid writes and confirms the outputs from the previous write are unchanged.

// File: rtl/mixdec_pkg.sv
package mixdec_pkg;
    localparam int BYTE_W     = 8;
    localparam int VOL_W      = 5;
    localparam int GAIN_W     = 8;
    localparam int MODE_W     = 3;
    localparam int FX_W       = 4;
    localparam int NSRC       = 3;
    localparam int SPK_OFFSET = 12;
    localparam int SPK_SRC_W  = NSRC;
    localparam int HP_SRC_W   = 2;

    localparam int SRC_MONO  = 0;
    localparam int SRC_LEFT  = 1;
    localparam int SRC_RIGHT = 2;

    typedef enum logic [1:0] {
        OUT_OFF  = 2'd0,
        OUT_MUTE = 2'd1,
        OUT_LIVE = 2'd2
    } out_state_e;

    typedef struct packed {
        logic                            no_cap;
        logic [MODE_W-1:0]               mode;
        logic [FX_W-1:0]                 fx;
        logic [NSRC-1:0][VOL_W-1:0]      vol;
    } ctl_t;
endpackage

// File: rtl/mixdec_regs.sv
module mixdec_regs
    import mixdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output ctl_t              ctl_d,
    output ctl_t              ctl_q
);
    logic [3:0] nib;
    logic [2:0] tri_pfx;

    assign nib     = wr_byte[BYTE_W-1 -: 4];
    assign tri_pfx = wr_byte[BYTE_W-1 -: 3];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_stb) begin
            if (nib == 4'b0000) begin
                ctl_d.no_cap = wr_byte[3];
                ctl_d.mode   = wr_byte[MODE_W-1:0];
            end else if (nib == 4'b0100) begin
                ctl_d.fx     = wr_byte[FX_W-1:0];
            end else if (tri_pfx == 3'b100) begin
                ctl_d.vol[SRC_MONO]  = wr_byte[VOL_W-1:0];
            end else if (tri_pfx == 3'b110) begin
                ctl_d.vol[SRC_LEFT]  = wr_byte[VOL_W-1:0];
            end else if (tri_pfx == 3'b111) begin
                ctl_d.vol[SRC_RIGHT] = wr_byte[VOL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R9: words outside the prefix code leave every field untouched
    assert_bad_prefix_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ((wr_byte[7:4] inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7})
                    || wr_byte[7:5] == 3'b101)) |=> $stable(ctl_q));

    // R4: a volume word never alters mode or effect fields
    assert_vol_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_byte[7] == 1'b1) |=> ($stable(ctl_q.mode) && $stable(ctl_q.fx)
                                            && $stable(ctl_q.no_cap)));
endmodule

// File: rtl/mixdec_gain.sv
module mixdec_gain #(
    parameter int VOL_W     = 5,
    parameter int GAIN_W    = 8,
    parameter int SPK_OFS   = 12,
    parameter int LIN_START = 10,
    parameter int LIN_BASE  = -27,
    parameter int LIN_STEP  = 3
) (
    input  logic [VOL_W-1:0]         code,
    output logic signed [GAIN_W-1:0] hp_gain,
    output logic signed [GAIN_W-1:0] spk_gain
);
    localparam int MAX_CODE = (1 << VOL_W) - 1;
    localparam int TOP_GAIN = LIN_BASE + LIN_STEP * (MAX_CODE - LIN_START);

    int g;

    always_comb begin
        case (code)
            5'd0:    g = -108;
            5'd1:    g = -93;
            5'd2:    g = -81;
            5'd3:    g = -69;
            5'd4:    g = -60;
            5'd5:    g = -54;
            5'd6:    g = -48;
            5'd7:    g = -42;
            5'd8:    g = -36;
            5'd9:    g = -30;
            default: g = LIN_BASE + LIN_STEP * (int'(code) - LIN_START);
        endcase
        hp_gain  = GAIN_W'(g);
        spk_gain = GAIN_W'(g + SPK_OFS);
    end

    // R5: headphone gain stays inside the curve's end points
    always_comb begin
        if (!$isunknown(code)) begin
            assert_gain_in_range_R5: assert (g >= -108 && g <= TOP_GAIN);
        end
    end
endmodule

// File: rtl/mixdec_route.sv
module mixdec_route
    import mixdec_pkg::*;
(
    input  logic [MODE_W-1:0]    mode,
    output out_state_e           spk_st,
    output out_state_e           hp_st_l,
    output out_state_e           hp_st_r,
    output logic [SPK_SRC_W-1:0] spk_src,
    output logic [HP_SRC_W-1:0]  hp_src
);
    always_comb begin
        spk_st  = OUT_OFF;
        hp_st_l = OUT_OFF;
        hp_st_r = OUT_OFF;
        spk_src = '0;
        hp_src  = '0;
        case (mode)
            3'd1: begin
                spk_st = OUT_LIVE; spk_src = 3'b100;
                hp_st_l = OUT_MUTE; hp_st_r = OUT_MUTE;
            end
            3'd2: begin
                hp_st_l = OUT_LIVE; hp_st_r = OUT_LIVE; hp_src = 2'b10;
            end
            3'd3: begin
                spk_st = OUT_LIVE; spk_src = 3'b011;
                hp_st_l = OUT_MUTE; hp_st_r = OUT_MUTE;
            end
            3'd4: begin
                hp_st_l = OUT_LIVE; hp_st_r = OUT_LIVE; hp_src = 2'b01;
            end
            3'd5: begin
                spk_st = OUT_LIVE; spk_src = 3'b111;
                hp_st_l = OUT_MUTE; hp_st_r = OUT_MUTE;
            end
            3'd6: begin
                hp_st_l = OUT_LIVE; hp_st_r = OUT_LIVE; hp_src = 2'b11;
            end
            3'd7: begin
                spk_st = OUT_LIVE; spk_src = 3'b100;
                hp_st_l = OUT_LIVE; hp_st_r = OUT_LIVE; hp_src = 2'b11;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mix_ctl_decoder.sv
module mix_ctl_decoder
    import mixdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic [7:0]  wr_byte,
    output logic [1:0]  spk_state,
    output logic [1:0]  hpl_state,
    output logic [1:0]  hpr_state,
    output logic [2:0]  spk_route,
    output logic [1:0]  hpl_route,
    output logic [1:0]  hpr_route,
    output logic [7:0]  gain_hp_mono,
    output logic [7:0]  gain_hp_left,
    output logic [7:0]  gain_hp_right,
    output logic [7:0]  gain_spk_mono,
    output logic [7:0]  gain_spk_left,
    output logic [7:0]  gain_spk_right,
    output logic        fx_en,
    output logic        fx_cfg,
    output logic [1:0]  fx_level,
    output logic        hp_no_cap
);
    typedef struct packed {
        logic [1:0]                  spk_st;
        logic [1:0]                  hpl_st;
        logic [1:0]                  hpr_st;
        logic [SPK_SRC_W-1:0]        spk_src;
        logic [HP_SRC_W-1:0]         hpl_src;
        logic [HP_SRC_W-1:0]         hpr_src;
        logic [NSRC-1:0][GAIN_W-1:0] hp_g;
        logic [NSRC-1:0][GAIN_W-1:0] spk_g;
        logic [FX_W-1:0]             fx;
        logic                        no_cap;
    } out_t;

    ctl_t                        ctl_d;
    ctl_t                        ctl_q;
    out_state_e                  r_spk_st;
    out_state_e                  r_hpl_st;
    out_state_e                  r_hpr_st;
    logic [SPK_SRC_W-1:0]        r_spk_src;
    logic [HP_SRC_W-1:0]         r_hp_src;
    logic [NSRC-1:0][GAIN_W-1:0] hp_g;
    logic [NSRC-1:0][GAIN_W-1:0] spk_g;
    out_t                        out_d;
    out_t                        out_q;

    mixdec_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .ctl_d   (ctl_d),
        .ctl_q   (ctl_q)
    );

    mixdec_route u_route (
        .mode    (ctl_d.mode),
        .spk_st  (r_spk_st),
        .hp_st_l (r_hpl_st),
        .hp_st_r (r_hpr_st),
        .spk_src (r_spk_src),
        .hp_src  (r_hp_src)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        mixdec_gain #(
            .VOL_W   (VOL_W),
            .GAIN_W  (GAIN_W),
            .SPK_OFS (SPK_OFFSET)
        ) u_gain (
            .code     (ctl_d.vol[s]),
            .hp_gain  (hp_g[s]),
            .spk_gain (spk_g[s])
        );
    end

    always_comb begin
        out_d         = out_q;
        out_d.spk_st  = r_spk_st;
        out_d.hpl_st  = r_hpl_st;
        out_d.hpr_st  = r_hpr_st;
        out_d.spk_src = r_spk_src;
        out_d.hpl_src = r_hp_src;
        out_d.hpr_src = r_hp_src;
        out_d.hp_g    = hp_g;
        out_d.spk_g   = spk_g;
        out_d.fx      = ctl_d.fx;
        out_d.no_cap  = ctl_d.no_cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q        <= '0;
            out_q.hp_g   <= {NSRC{GAIN_W'(-108)}};
            out_q.spk_g  <= {NSRC{GAIN_W'(-108 + SPK_OFFSET)}};
        end else begin
            out_q <= out_d;
        end
    end

    assign spk_state      = out_q.spk_st;
    assign hpl_state      = out_q.hpl_st;
    assign hpr_state      = out_q.hpr_st;
    assign spk_route      = out_q.spk_src;
    assign hpl_route      = out_q.hpl_src;
    assign hpr_route      = out_q.hpr_src;
    assign gain_hp_mono   = out_q.hp_g[SRC_MONO];
    assign gain_hp_left   = out_q.hp_g[SRC_LEFT];
    assign gain_hp_right  = out_q.hp_g[SRC_RIGHT];
    assign gain_spk_mono  = out_q.spk_g[SRC_MONO];
    assign gain_spk_left  = out_q.spk_g[SRC_LEFT];
    assign gain_spk_right = out_q.spk_g[SRC_RIGHT];
    assign fx_en          = out_q.fx[0];
    assign fx_cfg         = out_q.fx[1];
    assign fx_level       = out_q.fx[3:2];
    assign hp_no_cap      = out_q.no_cap;

    // R8: a live speaker has at least one source, any other speaker state has none
    assert_spk_route_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spk_state == 2'd2) == (spk_route != 3'b000));

    // R7: muted or shut-down headphones carry no source
    assert_hp_quiet_no_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hpl_state != 2'd2) |-> (hpl_route == 2'b00 && hpr_route == 2'b00));

    // R10: with no strobe every output holds
    assert_hold_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(spk_state) && $stable(hpl_route) && $stable(gain_hp_mono)
                     && $stable(gain_hp_right) && $stable(fx_level) && $stable(hp_no_cap)));

    // R6: speaker gain and headphone gain of a source stay a fixed step apart
    assert_spk_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(gain_spk_left) == $signed(gain_hp_left) + 8'sd12);
endmodule

// File: tb/mix_ctl_decoder_tb.sv
module mix_ctl_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [1:0] spk_state, hpl_state, hpr_state;
    logic [2:0] spk_route;
    logic [1:0] hpl_route, hpr_route;
    logic [7:0] gain_hp_mono, gain_hp_left, gain_hp_right;
    logic [7:0] gain_spk_mono, gain_spk_left, gain_spk_right;
    logic       fx_en, fx_cfg, hp_no_cap;
    logic [1:0] fx_level;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mix_ctl_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .spk_state(spk_state), .hpl_state(hpl_state), .hpr_state(hpr_state),
        .spk_route(spk_route), .hpl_route(hpl_route), .hpr_route(hpr_route),
        .gain_hp_mono(gain_hp_mono), .gain_hp_left(gain_hp_left),
        .gain_hp_right(gain_hp_right), .gain_spk_mono(gain_spk_mono),
        .gain_spk_left(gain_spk_left), .gain_spk_right(gain_spk_right),
        .fx_en(fx_en), .fx_cfg(fx_cfg), .fx_level(fx_level), .hp_no_cap(hp_no_cap)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_hp(input int c);
        int lo[10] = '{-108, -93, -81, -69, -60, -54, -48, -42, -36, -30};
        if (c < 10) return lo[c];
        return -27 + 3 * (c - 10);
    endfunction

    function automatic int sg(input logic [7:0] v);
        return int'($signed(v));
    endfunction

    // drive at a falling edge, sample at the next falling edge
    task automatic write(input logic [7:0] b);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_byte = b;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic check_mode(input string req, input int m);
        int st[8][3] = '{'{0,0,0}, '{2,1,1}, '{0,2,2}, '{2,1,1},
                         '{0,2,2}, '{2,1,1}, '{0,2,2}, '{2,2,2}};
        int sr[8] = '{0, 4, 0, 3, 0, 7, 0, 4};
        int hr[8] = '{0, 0, 2, 0, 1, 0, 3, 3};
        check(req, $sformatf("mode%0d spk_state", m), int'(spk_state), st[m][0]);
        check(req, $sformatf("mode%0d hpl_state", m), int'(hpl_state), st[m][1]);
        check(req, $sformatf("mode%0d hpr_state", m), int'(hpr_state), st[m][2]);
        check(req, $sformatf("mode%0d spk_route", m), int'(spk_route), sr[m]);
        check(req, $sformatf("mode%0d hpl_route", m), int'(hpl_route), hr[m]);
        check(req, $sformatf("mode%0d hpr_route", m), int'(hpr_route), hr[m]);
    endtask

    task automatic t_reset();
        check_mode("R1", 0);
        check("R1", "hp_no_cap", int'(hp_no_cap), 0);
        check("R1", "gain_hp_mono", sg(gain_hp_mono), -108);
        check("R1", "gain_hp_right", sg(gain_hp_right), -108);
        check("R1", "gain_spk_left", sg(gain_spk_left), -96);
        check("R1", "fx", int'({fx_level, fx_cfg, fx_en}), 0);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 8; m++) begin
            write(8'(m));
            check_mode("R7", m);
            check_mode("R8", m);
        end
        write(8'b0000_1110);
        check("R2", "no_cap set", int'(hp_no_cap), 1);
        check_mode("R2", 6);
        write(8'b0000_0011);
        check("R2", "no_cap clear", int'(hp_no_cap), 0);
        check_mode("R2", 3);
    endtask

    task automatic t_fx();
        write(8'b0100_1001);
        check("R3", "fx_en", int'(fx_en), 1);
        check("R3", "fx_cfg", int'(fx_cfg), 0);
        check("R3", "fx_level high", int'(fx_level), 2);
        write(8'b0100_0110);
        check("R3", "fx_en off", int'(fx_en), 0);
        check("R3", "fx_cfg", int'(fx_cfg), 1);
        check("R3", "fx_level medium", int'(fx_level), 1);
        check("R3", "mode kept", int'(spk_state), 2);
    endtask

    task automatic t_volume();
        for (int c = 0; c < 32; c++) begin
            write(8'b1000_0000 | 8'(c));
            check("R5", $sformatf("hp gain code %0d", c), sg(gain_hp_mono), exp_hp(c));
            check("R6", $sformatf("spk gain code %0d", c), sg(gain_spk_mono), exp_hp(c) + 12);
        end
        write(8'b1100_0111);
        check("R4", "left vol", sg(gain_hp_left), exp_hp(7));
        check("R4", "mono kept", sg(gain_hp_mono), exp_hp(31));
        check("R4", "right kept", sg(gain_hp_right), exp_hp(0));
        write(8'b1111_0100);
        check("R4", "right vol", sg(gain_hp_right), exp_hp(20));
        check("R6", "right spk", sg(gain_spk_right), exp_hp(20) + 12);
        check("R4", "left kept", sg(gain_hp_left), exp_hp(7));
    endtask

    task automatic t_ignore();
        logic [7:0] bad[7] = '{8'h1F, 8'h2A, 8'h35, 8'h5F, 8'h6C, 8'h7B, 8'hBF};
        write(8'h05);
        write(8'h4D);
        foreach (bad[i]) begin
            write(bad[i]);
            check_mode("R9", 5);
            check("R9", $sformatf("fx after %02h", bad[i]), int'({fx_level, fx_cfg, fx_en}), 4'hD);
            check("R9", $sformatf("mono after %02h", bad[i]), sg(gain_hp_mono), exp_hp(31));
            check("R9", $sformatf("left after %02h", bad[i]), sg(gain_hp_left), exp_hp(7));
            check("R9", $sformatf("right after %02h", bad[i]), sg(gain_hp_right), exp_hp(20));
            check("R9", $sformatf("no_cap after %02h", bad[i]), int'(hp_no_cap), 0);
        end
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        wr_stb = 1'b1; wr_byte = 8'b0000_1111;
        @(negedge clk);
        check_mode("R10", 7);
        check("R10", "no_cap b2b", int'(hp_no_cap), 1);
        wr_byte = 8'b1100_1010;
        @(negedge clk);
        check("R10", "left b2b", sg(gain_hp_left), exp_hp(10));
        check_mode("R10", 7);
        wr_byte = 8'b0100_1111;
        @(negedge clk);
        check("R10", "fx b2b", int'({fx_level, fx_cfg, fx_en}), 15);
        check("R10", "left held b2b", sg(gain_hp_left), exp_hp(10));
        wr_byte = 8'b0000_0100;
        @(negedge clk);
        check_mode("R10", 4);
        check("R10", "no_cap b2b clear", int'(hp_no_cap), 0);
        wr_stb = 1'b0;
        wr_byte = 8'h00;
        @(negedge clk);
        wr_byte = 8'h9F;
        @(negedge clk);
        wr_byte = 8'h01;
        @(negedge clk);
        check_mode("R10", 4);
        check("R10", "mono held no strobe", sg(gain_hp_mono), exp_hp(31));
        check("R10", "fx held no strobe", int'({fx_level, fx_cfg, fx_en}), 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_fx();
        t_volume();
        t_ignore();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000 && !done) begin
                checks++;
                failures++;
                $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 50000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule